// File: doc/BRIEF.md
# Five-Level Wavelet Pyramid Filter Bank

This block splits a stream of signed 16-bit neural samples into six frequency bands. Each level holds a quadrature-mirror pair of fixed 8-tap filters. The low-pass branch gives the smooth approximation and the high-pass branch gives the detail. Level k runs only on every second sample that reaches it. Its high-pass result is sent out as detail band k. Its low-pass result becomes the next input sample of level k+1. The low-pass result of the last level is sent out as band 5, the coarsest approximation.

All levels share one filter core. The core picks the delay line of the level being worked on, so a sample that triggers several levels is handled one level per cycle. Results leave through one port: a one-cycle `out_valid` pulse, a 3-bit band number and the data. A small state machine runs this sequence:

- `ST_IDLE`: `in_ready` is high.
  - `ACCEPT_SKIP`: the accepted sample is an odd-numbered arrival at level 0. The machine stays in `ST_IDLE`.
  - `ACCEPT_RUN`: the accepted sample is even-numbered. The machine goes to `ST_LEVEL`.
- `ST_LEVEL`: one level is filtered and its detail band is emitted.
  - `DESCEND`: the next level also fires. The level counter steps up.
  - `SETTLE`: the next level only stores the sample. The machine goes back to `ST_IDLE`.
  - `LAST_LEVEL`: the last level has been filtered. The machine goes to `ST_APPROX`.
- `ST_APPROX`: band 5 is emitted.
  - `EMIT_DONE`: the machine returns to `ST_IDLE`.

The filter products use no multiplier. Each product is a sum of shifted copies of the sample. A shared 3x term is used for both filters of the same tap.

Top module: `wavelet_pyramid`

## Requirements
- R1: `in_ready` is high only in the idle state. A sample is taken only on a rising edge where `in_valid` and `in_ready` are both high. A sample held on `in_sample` while `in_ready` is low has no effect. An idle cycle without a sample produces no output in the next cycle.
- R2: The filters compute y = sum over i = 0..7 of c[i]·x[n−i], where x[n] is the newest sample in the level. The low-pass taps c are 236, 732, 646, −29, −192, 32, 34, −11. The high-pass taps are −11, −34, 32, 192, −29, −646, 732, −236.
- R3: Each filter sum is shifted right arithmetically by 10 bits, which rounds toward minus infinity. The result is then clamped to the range −32768..32767. The clamped low-pass value is what enters the next level.
- R4: A level fires on the 2nd, 4th, 6th … sample it receives after reset. After N accepted inputs, band k (0..4) has been emitted floor(N/2^(k+1)) times and band 5 floor(N/32) times.
- R5: Bands 0..4 carry the high-pass result of levels 0..4, with the band number on `out_band`. Band 5 carries the low-pass result of level 4. `out_band` never exceeds 5.
- R6: Band k (0..4) appears k+1 cycles after the edge that accepted the input sample. Band 5 appears one cycle after band 4. Every `out_valid` pulse lasts exactly one cycle.
- R7: The bands caused by one input sample come out in ascending order, one per cycle. `in_ready` stays low until the last of them is out.
- R8: Synchronous reset clears every delay line and every decimation phase to zero. In the cycle after reset, `out_valid` is low and `in_ready` is high.
- R9: Once eight equal samples fill level 0, detail band 0 is exactly zero, because the high-pass taps sum to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new sample is offered |
| in_sample | input | 16 | Signed input sample |
| in_ready | output | 1 | The block can take a sample this cycle |
| out_valid | output | 1 | One-cycle strobe for a band result |
| out_band | output | 3 | Band number 0..5 |
| out_data | output | 16 | Signed, saturated band value |

## Verification
Every accepted sample is recorded in a bit-accurate integer model in the bench. The model is stamped with the number of the accepting edge. Each band the model predicts is queued with its due cycle: k+1 cycles after acceptance for detail band k, and six cycles after acceptance for band 5. The bench reads the outputs at the falling edge and compares band, value and arrival cycle against the head of the queue. A band that arrives early, late or out of order therefore fails at once, even if its value is right. When the queue is drained, `in_ready` is checked, and the number of outputs per band is compared with the decimation formula.

// File: rtl/wv_pkg.sv
package wv_pkg;

    localparam int TAPS      = 8;
    localparam int COEF_W    = 12;
    localparam int COEF_FRAC = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEVEL,
        ST_APPROX
    } wv_state_e;

    // Smoothing taps, scaled by 2^COEF_FRAC, index 0 multiplies newest sample
    function automatic int lp_coef(input int i);
        case (i)
            0:       return 236;
            1:       return 732;
            2:       return 646;
            3:       return -29;
            4:       return -192;
            5:       return 32;
            6:       return 34;
            default: return -11;
        endcase
    endfunction

    // Mirror filter: reversed smoothing taps with alternating sign
    function automatic int hp_coef(input int i);
        int s;
        s = ((i % 2) == 0) ? 1 : -1;
        return s * lp_coef(TAPS - 1 - i);
    endfunction

endpackage

// File: rtl/wv_tap_pair.sv
module wv_tap_pair
    import wv_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int C_LP   = 0,
    parameter int C_HP   = 0
) (
    input  logic signed [DATA_W-1:0]        x,
    output logic signed [DATA_W+COEF_W-1:0] p_lp,
    output logic signed [DATA_W+COEF_W-1:0] p_hp
);
    localparam int PW     = DATA_W + COEF_W;
    localparam int DIGITS = COEF_W / 2;

    logic signed [PW-1:0] x1;
    logic signed [PW-1:0] x3;

    assign x1 = PW'(x);
    // the 3x term is built once and reused by both constant products
    assign x3 = (x1 <<< 1) + x1;

    // radix-4 recoding of the constant magnitude: each digit adds 0, x, 2x or 3x
    function automatic logic signed [PW-1:0] shadd(
        input int                   c,
        input logic signed [PW-1:0] v1,
        input logic signed [PW-1:0] v3
    );
        int                   m;
        logic signed [PW-1:0] acc;
        m   = (c < 0) ? -c : c;
        acc = '0;
        for (int d = 0; d < DIGITS; d++) begin
            case ((m >> (2 * d)) & 3)
                1:       acc = acc + (v1 <<< (2 * d));
                2:       acc = acc + (v1 <<< (2 * d + 1));
                3:       acc = acc + (v3 <<< (2 * d));
                default: acc = acc;
            endcase
        end
        return (c < 0) ? -acc : acc;
    endfunction

    assign p_lp = shadd(C_LP, x1, x3);
    assign p_hp = shadd(C_HP, x1, x3);

endmodule

// File: rtl/wv_qmf_core.sv
module wv_qmf_core
    import wv_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] taps [TAPS],
    output logic signed [DATA_W-1:0] lp_q,
    output logic signed [DATA_W-1:0] hp_q
);
    localparam int PW    = DATA_W + COEF_W;
    localparam int ACC_W = PW + $clog2(TAPS);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

    logic signed [PW-1:0]    p_lp [TAPS];
    logic signed [PW-1:0]    p_hp [TAPS];
    logic signed [ACC_W-1:0] acc_lp;
    logic signed [ACC_W-1:0] acc_hp;
    logic signed [ACC_W-1:0] sh_lp;
    logic signed [ACC_W-1:0] sh_hp;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        wv_tap_pair #(
            .DATA_W (DATA_W),
            .C_LP   (lp_coef(i)),
            .C_HP   (hp_coef(i))
        ) u_pair (
            .x    (taps[i]),
            .p_lp (p_lp[i]),
            .p_hp (p_hp[i])
        );
    end

    always_comb begin
        acc_lp = '0;
        acc_hp = '0;
        for (int i = 0; i < TAPS; i++) begin
            acc_lp = acc_lp + ACC_W'(p_lp[i]);
            acc_hp = acc_hp + ACC_W'(p_hp[i]);
        end
    end

    assign sh_lp = acc_lp >>> COEF_FRAC;
    assign sh_hp = acc_hp >>> COEF_FRAC;

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v > SAT_HI)      return SAT_HI[DATA_W-1:0];
        else if (v < SAT_LO) return SAT_LO[DATA_W-1:0];
        else                 return v[DATA_W-1:0];
    endfunction

    assign lp_q = clamp(sh_lp);
    assign hp_q = clamp(sh_hp);

    // R9: a flat window must give a zero detail value
    logic flat;
    always_comb begin
        flat = 1'b1;
        for (int i = 1; i < TAPS; i++)
            if (taps[i] != taps[0]) flat = 1'b0;
        if (flat) begin
            p_dc_detail_zero_r9: assert (hp_q == '0)
                else $error("detail of flat window not zero");
        end
    end

endmodule

// File: rtl/wavelet_pyramid.sv
module wavelet_pyramid
    import wv_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEVELS = 5
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic signed [DATA_W-1:0]             in_sample,
    output logic                                 in_ready,
    output logic                                 out_valid,
    output logic [$clog2(LEVELS+1)-1:0]          out_band,
    output logic signed [DATA_W-1:0]             out_data
);
    localparam int                BAND_W  = $clog2(LEVELS + 1);
    localparam logic [BAND_W-1:0] LAST    = BAND_W'(LEVELS - 1);
    localparam logic [BAND_W-1:0] APPROX  = BAND_W'(LEVELS);

    wv_state_e                 state, state_nx;
    logic [BAND_W-1:0]         lvl, lvl_nx, nxt_lvl;
    logic signed [DATA_W-1:0]  line [LEVELS][TAPS];
    logic [LEVELS-1:0]         phase;
    logic signed [DATA_W-1:0]  sel_taps [TAPS];
    logic signed [DATA_W-1:0]  lp_q, hp_q;
    logic signed [DATA_W-1:0]  approx_q;
    logic                      accept;
    logic                      wr_en;
    logic [BAND_W-1:0]         wr_lvl;
    logic signed [DATA_W-1:0]  wr_data;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign nxt_lvl  = lvl + BAND_W'(1);

    // pick the delay line of the level under work
    always_comb begin
        sel_taps = line[0];
        for (int k = 1; k < LEVELS; k++)
            if (lvl == BAND_W'(k)) sel_taps = line[k];
    end

    wv_qmf_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .taps (sel_taps),
        .lp_q (lp_q),
        .hp_q (hp_q)
    );

    // next-state and line-write control
    always_comb begin
        state_nx = state;
        lvl_nx   = lvl;
        wr_en    = 1'b0;
        wr_lvl   = '0;
        wr_data  = in_sample;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    wr_en  = 1'b1;
                    lvl_nx = '0;
                    if (phase[0]) state_nx = ST_LEVEL;      // ACCEPT_RUN
                end                                          // else ACCEPT_SKIP
            end
            ST_LEVEL: begin
                if (lvl == LAST) begin
                    state_nx = ST_APPROX;                    // LAST_LEVEL
                end else begin
                    wr_en   = 1'b1;
                    wr_lvl  = nxt_lvl;
                    wr_data = lp_q;
                    if (phase[nxt_lvl]) lvl_nx = nxt_lvl;    // DESCEND
                    else state_nx = ST_IDLE;                 // SETTLE
                end
            end
            ST_APPROX: state_nx = ST_IDLE;                   // EMIT_DONE
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            lvl   <= '0;
        end else begin
            state <= state_nx;
            lvl   <= lvl_nx;
        end
    end

    // delay lines and decimation phases
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LEVELS; k++)
                for (int i = 0; i < TAPS; i++)
                    line[k][i] <= '0;
            phase <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < LEVELS; k++) begin
                if (wr_lvl == BAND_W'(k)) begin
                    line[k][0] <= wr_data;
                    for (int i = 1; i < TAPS; i++)
                        line[k][i] <= line[k][i-1];
                    phase[k] <= ~phase[k];
                end
            end
        end
    end

    // band emission
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_band  <= '0;
            out_data  <= '0;
            approx_q  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_LEVEL: begin
                    out_valid <= 1'b1;
                    out_band  <= lvl;
                    out_data  <= hp_q;
                    if (lvl == LAST) approx_q <= lp_q;
                end
                ST_APPROX: begin
                    out_valid <= 1'b1;
                    out_band  <= APPROX;
                    out_data  <= approx_q;
                end
                default: ;
            endcase
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

    p_band_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_band <= APPROX));

    p_approx_single_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_band == APPROX) |=> !out_valid);

    p_band_step_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_band != '0) |->
            ($past(out_valid) && ($past(out_band) == out_band - BAND_W'(1))));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

endmodule

// File: tb/wavelet_pyramid_test.sv
module wavelet_pyramid_test;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               in_ready;
    logic               out_valid;
    logic [2:0]         out_band;
    logic signed [15:0] out_data;

    wavelet_pyramid uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_band  (out_band),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // ---------------- reference model ----------------
    int hco [8] = '{236, 732, 646, -29, -192, 32, 34, -11};
    int gco [8] = '{-11, -34, 32, 192, -29, -646, 732, -236};
    int mline [5][8];
    bit mph [5];
    int q_band[$], q_data[$], q_cyc[$];
    int n_acc;
    int obs [6];
    bit dc_mode = 0;
    int dc_cnt  = 0;

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int filt(input int k, input bit hi);
        longint a = 0;
        for (int i = 0; i < 8; i++)
            a += longint'(hi ? gco[i] : hco[i]) * longint'(mline[k][i]);
        return sat16(a >>> 10);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) begin
            mph[k] = 0;
            for (int i = 0; i < 8; i++) mline[k][i] = 0;
        end
        for (int b = 0; b < 6; b++) obs[b] = 0;
        n_acc = 0;
    endtask

    task automatic model_push(input int s, input int acc_cyc);
        int v;
        bit was;
        v = s;
        n_acc++;
        if (dc_mode) dc_cnt++;
        for (int k = 0; k < 5; k++) begin
            for (int i = 7; i > 0; i--) mline[k][i] = mline[k][i-1];
            mline[k][0] = v;
            was = mph[k];
            mph[k] = !mph[k];
            if (!was) return;
            q_band.push_back(k);
            q_data.push_back(filt(k, 1'b1));
            q_cyc.push_back(acc_cyc + k + 1);
            v = filt(k, 1'b0);
            if (k == 4) begin
                q_band.push_back(5);
                q_data.push_back(v);
                q_cyc.push_back(acc_cyc + 6);
            end
        end
    endtask

    // ---------------- output monitor ----------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q_cyc.size() != 0 && q_cyc[0] < cyc) begin
                chk(1'b0, "R6 band missing at due cycle", cyc, q_cyc[0]);
                void'(q_band.pop_front()); void'(q_data.pop_front()); void'(q_cyc.pop_front());
            end
            if (out_valid) begin
                if (q_band.size() == 0) begin
                    chk(1'b0, "R4 unexpected output band", out_band, -1);
                end else begin
                    int eb, ed, ec;
                    eb = q_band.pop_front();
                    ed = q_data.pop_front();
                    ec = q_cyc.pop_front();
                    obs[out_band]++;
                    chk(out_band == eb, "R5 band number", out_band, eb);
                    chk(out_data == ed, "R2 R3 band value", out_data, ed);
                    chk(cyc == ec, "R6 arrival cycle", cyc, ec);
                    if (q_cyc.size() != 0 && q_cyc[0] == cyc + 1)
                        chk(!in_ready, "R7 ready low while bands pending", in_ready, 0);
                    else
                        chk(in_ready, "R1 ready after last band", in_ready, 1);
                    if (dc_mode && dc_cnt >= 10 && out_band == 0)
                        chk(out_data == 0, "R9 flat input detail zero", out_data, 0);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input int s, input bit gap);
        bit r;
        if (gap) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid  = 1'b1;
        in_sample = 16'(s);
        forever begin
            r = in_ready;
            if (r) model_push(s, cyc + 1);
            @(negedge clk);
            if (r) break;
        end
    endtask

    task automatic drain();
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(q_band.size() == 0, "R4 all expected bands emitted", q_band.size(), 0);
        chk(in_ready, "R1 ready when drained", in_ready, 1);
    endtask

    task automatic count_check();
        for (int b = 0; b < 6; b++) begin
            int e;
            e = (b < 5) ? (n_acc >> (b + 1)) : (n_acc >> 5);
            chk(obs[b] == e, $sformatf("R4 band %0d output count", b), obs[b], e);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk(!out_valid, "R8 out_valid low after reset", out_valid, 0);
        chk(in_ready, "R8 ready after reset", in_ready, 1);
    endtask

    initial begin
        int seed;
        model_reset();
        do_reset();
        chk(out_data == 0, "R8 out_data cleared", out_data, 0);

        // impulse with gaps between samples
        send(1000, 1'b0);
        for (int n = 0; n < 63; n++) send(0, n % 3 == 0);
        drain();
        count_check();

        // flat input
        do_reset();
        dc_mode = 1;
        for (int n = 0; n < 64; n++) send(1200, 1'b0);
        drain();
        dc_mode = 0;
        count_check();

        // full-scale alternation drives the detail path into saturation
        do_reset();
        for (int n = 0; n < 64; n++) send((n % 2 == 0) ? 32767 : -32768, 1'b0);
        drain();
        count_check();

        // pseudo-random stream, in_valid held high while busy
        do_reset();
        seed = 12345;
        for (int n = 0; n < 640; n++) begin
            seed = seed * 1103515245 + 12345;
            send((seed >>> 8) % 32768, n % 17 == 0);
        end
        drain();
        count_check();

        // reset in mid-stream must wipe delay lines and phases
        for (int n = 0; n < 3; n++) send(20000 - n * 3000, 1'b0);
        drain();
        do_reset();
        send(5000, 1'b0);
        for (int n = 0; n < 31; n++) send(n * 100 - 1500, 1'b0);
        drain();
        count_check();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule